// File: doc/BRIEF.md
# Processor Exception Entry Controller

This block sits next to the execute stage of a small processor core. Each cycle it looks at the pending exception causes: reset, undefined instruction, software interrupt, prefetch abort, data abort, normal interrupt and fast interrupt. It picks one cause by fixed priority. On the next clock edge it performs the whole entry in one update:

- the current status word is saved into the banked saved-status register of the target mode;
- the return address is written into that mode's banked link register;
- the mode, state and mask bits of the status word are rewritten;
- the program counter is loaded with the handler's vector.

The block also handles the return path. A return strobe loads the program counter. In the same edge it copies the saved status of the current mode back into the current status word. A direct status write lets software enter the user and system modes, which have no exception of their own.

Status word layout:

| Bits | Meaning |
|------|---------|
| [4:0] | Mode |
| [5] | Compressed-instruction state (1 = compressed) |
| [6] | Fast-interrupt mask |
| [7] | Interrupt mask |

Entry and return keep all other bits as they are.

Top module: `excEntryCtl`

## Requirements
- R1: On entry, the status word present before the edge is stored in the saved-status bank of the target mode. After entry, `curSpsr` shows that value. Other banks keep their contents.
- R2: Entry takes effect on the clock edge after the winning request is seen. `pc` becomes the vector, the mode field becomes the target mode, and `curLr` shows the `retPc` that was sampled. `excTaken` is high for that one cycle and `excKind` names the cause.
- R3: Every entry clears bit 5 and sets bit 7. Bit 6 is set by reset and fast-interrupt entry; every other entry leaves it unchanged. Bits [31:8] are preserved.
- R4: A reset request wins over any other pending request.
- R5: Below reset, the priority order is: data abort, fast interrupt, interrupt, prefetch abort, undefined instruction, software interrupt.
- R6: An undefined-instruction request is taken only while `cpAccept` is low. When `cpAccept` is high, the request has no effect on the status word or on `pc`.
- R7: The vector is `excKind`×4. The kinds and target modes are:

  | Cause | `excKind` | Target mode |
  |-------|-----------|-------------|
  | Reset | 0 | supervisor |
  | Undefined instruction | 1 | undefined |
  | Software interrupt | 2 | supervisor |
  | Prefetch abort | 3 | abort |
  | Data abort | 4 | abort |
  | Interrupt | 6 | interrupt (vector 0x18) |
  | Fast interrupt | 7 | fast interrupt |

  Kind 5 (address 0x14) is never produced.
- R8: Mode codes are: user 10000, fast interrupt 10001, interrupt 10010, supervisor 10011, abort 10111, undefined 11011, system 11111.
  - `wrCpsr` loads `cpsrWrData` into the status word.
  - In user or system mode, `curSpsr` and `curLr` read 0.
  - In user or system mode, a return leaves the status word unchanged.
- R9: `excRet` with no exception pending loads `pc` from `retTarget`. In the same edge it copies the current mode's saved status into the status word. An exception in the same cycle takes precedence over a return, and a return takes precedence over a status write.
- R10: An interrupt request is ignored while bit 7 is set. A fast-interrupt request is ignored while bit 6 is set.
- R11: After block reset (`rstN` low), the status word is 0x000000D3 (supervisor, both masks set, full-width state), `pc` is 0, all banks are 0 and `excTaken` is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low block reset |
| reqReset | input | 1 | Reset exception request |
| reqUndef | input | 1 | Unrecognised instruction has reached execute |
| cpAccept | input | 1 | A coprocessor accepts the instruction in execute |
| reqSwi | input | 1 | Software interrupt request |
| reqPabt | input | 1 | Prefetch abort request |
| reqDabt | input | 1 | Data abort request |
| irqReq | input | 1 | Interrupt request level |
| fiqReq | input | 1 | Fast interrupt request level |
| retPc | input | AW | Return address saved into the banked link register |
| excRet | input | 1 | Return with status restore |
| retTarget | input | AW | Program counter value loaded by a return |
| wrCpsr | input | 1 | Direct status word write strobe |
| cpsrWrData | input | 32 | Value for a direct status write |
| cpsr | output | 32 | Current status word |
| pc | output | AW | Program counter |
| curLr | output | AW | Banked link register of the current mode |
| curSpsr | output | 32 | Saved-status register of the current mode |
| excTaken | output | 1 | Entry performed on the last edge |
| excKind | output | 3 | Cause of the last entry (vector/4) |

## Verification
A wrong arbitration decision shows at the very next edge: `excKind`, `pc` and the mode field then disagree with the expected winner. A corrupted bank entry stays hidden until that mode is current. It therefore shows either right after entry through `curSpsr`/`curLr`, or later when a return restores the wrong status word. For this reason the tests include nested entry followed by return, which reads back a bank written several cycles earlier. A mask or state bit that is handled wrongly shows directly on `cpsr` in the cycle after entry.

// File: rtl/excPkg.sv
package excPkg;
  localparam int NUM_BANKS = 5;
  localparam int BANK_W = $clog2(NUM_BANKS);

  localparam logic [4:0] MODE_USR = 5'b10000;
  localparam logic [4:0] MODE_FIQ = 5'b10001;
  localparam logic [4:0] MODE_IRQ = 5'b10010;
  localparam logic [4:0] MODE_SVC = 5'b10011;
  localparam logic [4:0] MODE_ABT = 5'b10111;
  localparam logic [4:0] MODE_UND = 5'b11011;
  localparam logic [4:0] MODE_SYS = 5'b11111;

  localparam logic [2:0] KIND_RST  = 3'd0;
  localparam logic [2:0] KIND_UND  = 3'd1;
  localparam logic [2:0] KIND_SWI  = 3'd2;
  localparam logic [2:0] KIND_PABT = 3'd3;
  localparam logic [2:0] KIND_DABT = 3'd4;
  localparam logic [2:0] KIND_IRQ  = 3'd6;
  localparam logic [2:0] KIND_FIQ  = 3'd7;

  localparam int BIT_T = 5;
  localparam int BIT_F = 6;
  localparam int BIT_I = 7;

  localparam logic [31:0] STATUS_RESET = 32'h0000_00D3;

  typedef struct packed {
    logic              enter;
    logic              restore;
    logic              write;
    logic [2:0]        kind;
    logic [4:0]        tgtMode;
    logic [BANK_W-1:0] tgtBank;
    logic              setF;
  } ctlT;

  // Bank slot for a mode; valid is 0 for user and system.
  function automatic logic [BANK_W:0] bankOf(input logic [4:0] mode);
    case (mode)
      MODE_SVC: bankOf = {1'b1, BANK_W'(0)};
      MODE_ABT: bankOf = {1'b1, BANK_W'(1)};
      MODE_UND: bankOf = {1'b1, BANK_W'(2)};
      MODE_IRQ: bankOf = {1'b1, BANK_W'(3)};
      MODE_FIQ: bankOf = {1'b1, BANK_W'(4)};
      default:  bankOf = '0;
    endcase
  endfunction
endpackage

// File: rtl/excArbiter.sv
module excArbiter
  import excPkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        reqReset,
  input  logic        reqUndef,
  input  logic        cpAccept,
  input  logic        reqSwi,
  input  logic        reqPabt,
  input  logic        reqDabt,
  input  logic        irqReq,
  input  logic        fiqReq,
  input  logic        excRet,
  input  logic        wrCpsr,
  input  logic [31:0] curCpsr,
  output ctlT         ctl
);
  logic fiqLive, irqLive, undLive, anyExc;

  assign fiqLive = fiqReq && !curCpsr[BIT_F];
  assign irqLive = irqReq && !curCpsr[BIT_I];
  assign undLive = reqUndef && !cpAccept;
  assign anyExc  = reqReset || reqDabt || fiqLive || irqLive || reqPabt || undLive || reqSwi;

  always_comb begin
    ctl = '0;
    ctl.enter   = anyExc;
    ctl.restore = !anyExc && excRet;
    ctl.write   = !anyExc && !excRet && wrCpsr;
    if (reqReset) begin
      ctl.kind = KIND_RST;  ctl.tgtMode = MODE_SVC; ctl.setF = 1'b1;
    end else if (reqDabt) begin
      ctl.kind = KIND_DABT; ctl.tgtMode = MODE_ABT;
    end else if (fiqLive) begin
      ctl.kind = KIND_FIQ;  ctl.tgtMode = MODE_FIQ; ctl.setF = 1'b1;
    end else if (irqLive) begin
      ctl.kind = KIND_IRQ;  ctl.tgtMode = MODE_IRQ;
    end else if (reqPabt) begin
      ctl.kind = KIND_PABT; ctl.tgtMode = MODE_ABT;
    end else if (undLive) begin
      ctl.kind = KIND_UND;  ctl.tgtMode = MODE_UND;
    end else if (reqSwi) begin
      ctl.kind = KIND_SWI;  ctl.tgtMode = MODE_SVC;
    end
    ctl.tgtBank = bankOf(ctl.tgtMode)[BANK_W-1:0];
  end

  AST_RESET_WINS: assert property (@(posedge clk) disable iff (!rstN)
    reqReset |-> (ctl.enter && ctl.kind == KIND_RST)); // R4
  AST_IRQ_MASKED: assert property (@(posedge clk) disable iff (!rstN)
    (irqReq && curCpsr[BIT_I] && !reqReset && !reqDabt && !fiqReq && !reqPabt && !reqUndef && !reqSwi)
      |-> !ctl.enter); // R10
  AST_UNDEF_GATED: assert property (@(posedge clk) disable iff (!rstN)
    (reqUndef && cpAccept && !reqReset && !reqDabt && !fiqReq && !irqReq && !reqPabt && !reqSwi)
      |-> !ctl.enter); // R6
  AST_ONE_ACTION: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({ctl.enter, ctl.restore, ctl.write})); // R9
endmodule

// File: rtl/excBankDp.sv
module excBankDp
  import excPkg::*;
#(
  parameter int AW = 32
) (
  input  logic          clk,
  input  logic          rstN,
  input  ctlT           ctl,
  input  logic [AW-1:0] retPc,
  input  logic [AW-1:0] retTarget,
  input  logic [31:0]   cpsrWrData,
  output logic [31:0]   cpsr,
  output logic [AW-1:0] pc,
  output logic [AW-1:0] curLr,
  output logic [31:0]   curSpsr,
  output logic          excTaken,
  output logic [2:0]    excKind
);
  logic [31:0]       spsrQ [NUM_BANKS];
  logic [AW-1:0]     lrQ   [NUM_BANKS];
  logic [BANK_W:0]   curSel;
  logic              curValid;
  logic [BANK_W-1:0] curIdx;

  assign curSel   = bankOf(cpsr[4:0]);
  assign curValid = curSel[BANK_W] && (int'(curSel[BANK_W-1:0]) < NUM_BANKS);
  assign curIdx   = curSel[BANK_W-1:0];
  assign curSpsr  = curValid ? spsrQ[curIdx] : '0;
  assign curLr    = curValid ? lrQ[curIdx] : '0;

  for (genvar b = 0; b < NUM_BANKS; b++) begin : gBank
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        spsrQ[b] <= '0;
        lrQ[b]   <= '0;
      end else if (ctl.enter && ctl.tgtBank == BANK_W'(b)) begin
        spsrQ[b] <= cpsr;
        lrQ[b]   <= retPc;
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cpsr     <= STATUS_RESET;
      pc       <= '0;
      excTaken <= 1'b0;
      excKind  <= '0;
    end else begin
      excTaken <= ctl.enter;
      if (ctl.enter) begin
        cpsr    <= {cpsr[31:8], 1'b1, cpsr[BIT_F] | ctl.setF, 1'b0, ctl.tgtMode};
        pc      <= AW'({ctl.kind, 2'b00});
        excKind <= ctl.kind;
      end else if (ctl.restore) begin
        if (curValid) cpsr <= curSpsr;
        pc <= retTarget;
      end else if (ctl.write) begin
        cpsr <= cpsrWrData;
      end
    end
  end

  AST_ENTRY_SAVES: assert property (@(posedge clk) disable iff (!rstN)
    ctl.enter |=> (curSpsr == $past(cpsr))); // R1
  AST_ENTRY_STATE: assert property (@(posedge clk) disable iff (!rstN)
    ctl.enter |=> (!cpsr[BIT_T] && cpsr[BIT_I])); // R3
  AST_ENTRY_VECTOR: assert property (@(posedge clk) disable iff (!rstN)
    ctl.enter |=> (pc == AW'({excKind, 2'b00}) && excTaken)); // R7
  AST_RETURN_RESTORES: assert property (@(posedge clk) disable iff (!rstN)
    (ctl.restore && curValid) |=> (cpsr == $past(curSpsr) && pc == $past(retTarget))); // R9
endmodule

// File: rtl/excEntryCtl.sv
module excEntryCtl
  import excPkg::*;
#(
  parameter int AW = 32
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          reqReset,
  input  logic          reqUndef,
  input  logic          cpAccept,
  input  logic          reqSwi,
  input  logic          reqPabt,
  input  logic          reqDabt,
  input  logic          irqReq,
  input  logic          fiqReq,
  input  logic [AW-1:0] retPc,
  input  logic          excRet,
  input  logic [AW-1:0] retTarget,
  input  logic          wrCpsr,
  input  logic [31:0]   cpsrWrData,
  output logic [31:0]   cpsr,
  output logic [AW-1:0] pc,
  output logic [AW-1:0] curLr,
  output logic [31:0]   curSpsr,
  output logic          excTaken,
  output logic [2:0]    excKind
);
  ctlT ctl;

  excArbiter uArb (
    .clk(clk), .rstN(rstN), .reqReset(reqReset), .reqUndef(reqUndef),
    .cpAccept(cpAccept), .reqSwi(reqSwi), .reqPabt(reqPabt), .reqDabt(reqDabt),
    .irqReq(irqReq), .fiqReq(fiqReq), .excRet(excRet), .wrCpsr(wrCpsr),
    .curCpsr(cpsr), .ctl(ctl)
  );

  excBankDp #(.AW(AW)) uDp (
    .clk(clk), .rstN(rstN), .ctl(ctl), .retPc(retPc), .retTarget(retTarget),
    .cpsrWrData(cpsrWrData), .cpsr(cpsr), .pc(pc), .curLr(curLr),
    .curSpsr(curSpsr), .excTaken(excTaken), .excKind(excKind)
  );
endmodule

// File: tb/sim_excEntryCtl.sv
`timescale 1ns/1ps
module sim_excEntryCtl;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic reqReset = 0, reqUndef = 0, cpAccept = 0, reqSwi = 0, reqPabt = 0, reqDabt = 0;
  logic irqReq = 0, fiqReq = 0, excRet = 0, wrCpsr = 0;
  logic [31:0] retPc = '0, retTarget = '0, cpsrWrData = '0;
  logic [31:0] cpsr, pc, curLr, curSpsr;
  logic excTaken;
  logic [2:0] excKind;
  int checks = 0, errors = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  excEntryCtl u0 (
    .clk(clk), .rstN(rstN), .reqReset(reqReset), .reqUndef(reqUndef), .cpAccept(cpAccept),
    .reqSwi(reqSwi), .reqPabt(reqPabt), .reqDabt(reqDabt), .irqReq(irqReq), .fiqReq(fiqReq),
    .retPc(retPc), .excRet(excRet), .retTarget(retTarget), .wrCpsr(wrCpsr),
    .cpsrWrData(cpsrWrData), .cpsr(cpsr), .pc(pc), .curLr(curLr), .curSpsr(curSpsr),
    .excTaken(excTaken), .excKind(excKind)
  );

  // req order: {reset, undef, swi, pabt, dabt, irq, fiq}
  typedef struct packed {
    logic [6:0] req;
    logic cpa;
    logic preI;
    logic preF;
    logic taken;
    logic [2:0] kind;
  } vecT;

  localparam int NV = 18;
  localparam vecT TBL [NV] = '{
    '{7'b1000000, 1'b0, 1'b0, 1'b0, 1'b1, 3'd0}, // R4 reset
    '{7'b0100000, 1'b0, 1'b0, 1'b0, 1'b1, 3'd1}, // R6 undef
    '{7'b0100000, 1'b1, 1'b0, 1'b0, 1'b0, 3'd0}, // R6 accepted by coprocessor
    '{7'b0010000, 1'b0, 1'b0, 1'b0, 1'b1, 3'd2}, // R7 swi
    '{7'b0001000, 1'b0, 1'b0, 1'b0, 1'b1, 3'd3}, // R7 pabt
    '{7'b0000100, 1'b0, 1'b0, 1'b0, 1'b1, 3'd4}, // R7 dabt
    '{7'b0000010, 1'b0, 1'b0, 1'b0, 1'b1, 3'd6}, // R7 irq at 0x18
    '{7'b0000001, 1'b0, 1'b0, 1'b0, 1'b1, 3'd7}, // R7 fiq
    '{7'b0000010, 1'b0, 1'b1, 1'b0, 1'b0, 3'd0}, // R10 irq masked
    '{7'b0000001, 1'b0, 1'b0, 1'b1, 1'b0, 3'd0}, // R10 fiq masked
    '{7'b1111111, 1'b0, 1'b0, 1'b0, 1'b1, 3'd0}, // R4 all pending
    '{7'b0000111, 1'b0, 1'b0, 1'b0, 1'b1, 3'd4}, // R5 dabt over fiq
    '{7'b0001011, 1'b0, 1'b0, 1'b0, 1'b1, 3'd7}, // R5 fiq over irq
    '{7'b0111010, 1'b0, 1'b0, 1'b0, 1'b1, 3'd6}, // R5 irq over pabt
    '{7'b0111000, 1'b0, 1'b0, 1'b0, 1'b1, 3'd3}, // R5 pabt over undef
    '{7'b0110000, 1'b0, 1'b0, 1'b0, 1'b1, 3'd1}, // R5 undef over swi
    '{7'b0110000, 1'b1, 1'b0, 1'b0, 1'b1, 3'd2}, // R6 accepted undef lets swi through
    '{7'b0000011, 1'b0, 1'b0, 1'b1, 1'b1, 3'd6}  // R10 masked fiq lets irq through
  };

  function automatic logic [4:0] modeFor(input logic [2:0] k);
    case (k)
      3'd1:       modeFor = 5'b11011;
      3'd3, 3'd4: modeFor = 5'b10111;
      3'd6:       modeFor = 5'b10010;
      3'd7:       modeFor = 5'b10001;
      default:    modeFor = 5'b10011;
    endcase
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic doReset();
    @(negedge clk) rstN = 1'b0;
    @(negedge clk);
    @(negedge clk) rstN = 1'b1;
  endtask

  task automatic writeStatus(input logic [31:0] v);
    @(negedge clk) begin wrCpsr = 1'b1; cpsrWrData = v; end
    @(negedge clk) wrCpsr = 1'b0;
  endtask

  task automatic setReq(input logic [6:0] r);
    {reqReset, reqUndef, reqSwi, reqPabt, reqDabt, irqReq, fiqReq} = r;
  endtask

  initial begin
    #(5ns * 20000);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog: actual running expected done");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [31:0] w, wIrq;
    doReset();
    // R11 reset state
    chk("R11 status", cpsr, 32'h0000_00D3);
    chk("R11 pc", pc, 32'h0);
    chk("R11 taken", {31'b0, excTaken}, 32'h0);
    chk("R11 spsr bank", curSpsr, 32'h0);

    for (int i = 0; i < NV; i++) begin
      vecT v = TBL[i];
      logic [31:0] wv, expS;
      doReset();
      wv = 32'hA000_0030 | (32'(v.preI) << 7) | (32'(v.preF) << 6);
      wv[4:0] = 5'b10000;
      writeStatus(wv);
      // request is applied right after the write edge settles
      setReq(v.req); cpAccept = v.cpa; retPc = 32'h400 + 32'(i) * 8;
      @(negedge clk) begin setReq('0); cpAccept = 1'b0; end
      if (v.taken) begin
        expS = {wv[31:8], 1'b1, wv[6] | (v.kind == 3'd0) | (v.kind == 3'd7), 1'b0, modeFor(v.kind)};
        chk($sformatf("R2,R4,R5 kind vec%0d", i), {29'b0, excKind}, {29'b0, v.kind});
        chk($sformatf("R2,R7 pc vec%0d", i), pc, 32'(v.kind) * 4);
        chk($sformatf("R3,R8 status vec%0d", i), cpsr, expS);
        chk($sformatf("R1 spsr vec%0d", i), curSpsr, wv);
        chk($sformatf("R2 lr vec%0d", i), curLr, 32'h400 + 32'(i) * 8);
        chk($sformatf("R2 taken vec%0d", i), {31'b0, excTaken}, 32'h1);
      end else begin
        chk($sformatf("R6,R10 status kept vec%0d", i), cpsr, wv);
        chk($sformatf("R6,R10 pc kept vec%0d", i), pc, 32'h0);
        chk($sformatf("R6,R10 taken vec%0d", i), {31'b0, excTaken}, 32'h0);
      end
    end

    // R2 taken is a one-cycle pulse
    @(negedge clk);
    chk("R2 taken drops", {31'b0, excTaken}, 32'h0);

    // nested entry and return: R1 R9 R8
    doReset();
    w = 32'h5000_0030;
    w[4:0] = 5'b10000;
    writeStatus(w);
    irqReq = 1'b1; retPc = 32'h1234;
    @(negedge clk) irqReq = 1'b0;
    wIrq = cpsr;
    chk("R7 irq vector", pc, 32'h18);
    fiqReq = 1'b1; retPc = 32'h5678;
    @(negedge clk) fiqReq = 1'b0;
    chk("R1 nested spsr", curSpsr, wIrq);
    chk("R1 nested lr", curLr, 32'h5678);
    chk("R3 fiq mask set", {31'b0, cpsr[6]}, 32'h1);
    excRet = 1'b1; retTarget = 32'h2000;
    @(negedge clk) excRet = 1'b0;
    chk("R9 restore to irq", cpsr, wIrq);
    chk("R9 return pc", pc, 32'h2000);
    chk("R1 irq bank kept", curLr, 32'h1234);
    chk("R1 irq spsr kept", curSpsr, w);
    excRet = 1'b1; retTarget = 32'h2400;
    @(negedge clk) excRet = 1'b0;
    chk("R9 restore to user", cpsr, w);
    chk("R8 user has no spsr", curSpsr, 32'h0);
    chk("R8 user lr reads zero", curLr, 32'h0);
    excRet = 1'b1; retTarget = 32'h3000;
    @(negedge clk) excRet = 1'b0;
    chk("R8 user return keeps status", cpsr, w);
    chk("R8 user return pc", pc, 32'h3000);
    writeStatus(32'h0000_001F);
    chk("R8 write system mode", cpsr, 32'h0000_001F);
    chk("R8 system has no spsr", curSpsr, 32'h0);

    // R9 exception beats return in the same cycle
    reqSwi = 1'b1; excRet = 1'b1; retTarget = 32'h7000; retPc = 32'h44;
    @(negedge clk) begin reqSwi = 1'b0; excRet = 1'b0; end
    chk("R9 exception over return pc", pc, 32'h8);
    chk("R9 exception over return spsr", curSpsr, 32'h0000_001F);

    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule